// File: doc/BRIEF.md
# Trimmed One-Second Divider with Test Pin

This block turns a 32,768 Hz oscillator enable into a one-cycle pulse per second and keeps the count of seconds within a minute and of minutes within a 64-minute trimming cycle. A calibration byte carries a sign and a 5-bit magnitude N. During the first 2×N minutes of each 64-minute cycle, the first second of every minute is made shorter or longer by a fixed number of oscillator enables. A shorter second makes the clock run faster. A longer second makes it run slower.

The same byte drives an open-drain pin, modelled here as a drive-low enable. In test mode the pin shows a square wave at 512 Hz (at default parameters). That wave comes from a free-running counter that trimming never touches. Outside test mode the pin shows a static level taken from a bit of the byte.

The byte is held inside the block and is loaded with a one-cycle write strobe. A stop input freezes all counting. A divider-clear input restarts the current minute. A power-down input forces test mode off.

Top module: `cal_trim_divider`

## Requirements
- R1: After reset, sec_tick is 0, sec_pos and min_pos are 0, and the held byte is 0x80 (level bit 1, test bit 0, sign 0, magnitude 0), so pin_drive_low is 0.
- R2: A cycle with cal_we high loads cal_wdata into the held byte. The fields are: bit 7 is the static level, bit 6 selects test mode, bit 5 is the sign (1 = faster), and bits 4:0 are the magnitude N in binary.
- R3: An untrimmed second lasts exactly OSC_PER_SEC cycles in which osc_en is high, whatever spacing the enables have. sec_tick is high for one clock cycle per second.
- R4: sec_pos advances on each tick and wraps after SEC_PER_MIN ticks. Each wrap advances min_pos, which wraps from 63 to 0. min_pos changes only together with a tick.
- R5: With sign 1 and minute index below 2×N, second 0 of that minute lasts OSC_PER_SEC−SHORTEN enables.
- R6: With sign 0 and minute index below 2×N, second 0 of that minute lasts OSC_PER_SEC+LENGTHEN enables.
- R7: Minutes with an index of 2×N or above, and every minute when N is 0, have only untrimmed seconds.
- R8: While stop_bit is high, no enable is counted, no tick is produced, and the test-wave level holds.
- R9: div_clr clears the sub-second count and sec_pos in the next cycle and leaves min_pos unchanged. The following second is then measured as second 0 of the same minute.
- R10: With test mode on and stop_bit low, pin_drive_low changes after every FT_HALF enables. Changing the sign or magnitude does not alter that interval.
- R11: With test mode off, pin_drive_low equals the inverse of the level bit (bit 7) from the cycle after the write.
- R12: pwr_down clears the test bit (bit 6), and it overrides a write in the same cycle. The pin then follows the level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator period |
| cal_we | input | 1 | Load strobe for the calibration byte |
| cal_wdata | input | 8 | Calibration byte: level, test, sign, magnitude |
| stop_bit | input | 1 | Freezes all counting while high |
| div_clr | input | 1 | Restarts the current minute |
| pwr_down | input | 1 | Forces test mode off |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| sec_pos | output | $clog2(SEC_PER_MIN) | Second index within the minute |
| min_pos | output | $clog2(MIN_PER_CYC) | Minute index within the trimming cycle |
| pin_drive_low | output | 1 | Pull the open-drain pin low when high |

## Verification
Trimming and the test wave run at the same time from the same enables. The bench therefore runs the test wave while the byte is rewritten with the largest positive trim, and it requires the wave's change interval to stay at FT_HALF.

A calibration write can land in the first cycle of a second that is about to be trimmed. The bench does exactly that after the last tick of a full 64-minute cycle, switching from positive to negative trim. It judges every following second by its tick-to-tick gap, measured against lengths it computes arithmetically.

A power-down in the same cycle as a write that sets test mode is also provoked. It is judged by the pin staying at the static level.

// File: rtl/cal_trim_divider.sv
module cal_trim_divider #(
  parameter int OSC_PER_SEC = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int SHORTEN     = 256,
  parameter int LENGTHEN    = 128,
  parameter int FT_HALF     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           osc_en,
  input  logic                           cal_we,
  input  logic [7:0]                     cal_wdata,
  input  logic                           stop_bit,
  input  logic                           div_clr,
  input  logic                           pwr_down,
  output logic                           sec_tick,
  output logic [$clog2(SEC_PER_MIN)-1:0] sec_pos,
  output logic [$clog2(MIN_PER_CYC)-1:0] min_pos,
  output logic                           pin_drive_low
);
  localparam int SUB_W = $clog2(OSC_PER_SEC + LENGTHEN);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(MIN_PER_CYC);
  localparam int FT_W  = $clog2(FT_HALF);
  localparam logic [SUB_W-1:0] LIM_NOM  = SUB_W'(OSC_PER_SEC - 1);
  localparam logic [SUB_W-1:0] LIM_FAST = SUB_W'(OSC_PER_SEC - SHORTEN - 1);
  localparam logic [SUB_W-1:0] LIM_SLOW = SUB_W'(OSC_PER_SEC + LENGTHEN - 1);

  logic [7:0]       cal_q;
  logic [SUB_W-1:0] sub_cnt;
  logic [SUB_W-1:0] lim;
  logic [FT_W-1:0]  ft_cnt;
  logic             ft_lvl;
  logic [MIN_W:0]   trim_span;
  logic             trim_now;

  wire run      = osc_en & ~stop_bit;
  wire sec_last = (sec_pos == SEC_W'(SEC_PER_MIN - 1));
  wire min_last = (min_pos == MIN_W'(MIN_PER_CYC - 1));

  assign trim_span = (MIN_W + 1)'({cal_q[4:0], 1'b0});
  assign trim_now  = (sec_pos == '0) && ({1'b0, min_pos} < trim_span);

  always_comb begin
    lim = LIM_NOM;
    if (trim_now) lim = cal_q[5] ? LIM_FAST : LIM_SLOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q <= 8'h80;
    end else begin
      if (cal_we)   cal_q    <= cal_wdata;
      if (pwr_down) cal_q[6] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_cnt  <= '0;
      sec_pos  <= '0;
      min_pos  <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= 1'b0;
      if (div_clr) begin
        sub_cnt <= '0;
        sec_pos <= '0;
      end else if (run) begin
        if (sub_cnt >= lim) begin
          sub_cnt  <= '0;
          sec_tick <= 1'b1;
          if (sec_last) begin
            sec_pos <= '0;
            min_pos <= min_last ? '0 : min_pos + 1'b1;
          end else begin
            sec_pos <= sec_pos + 1'b1;
          end
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ft_cnt <= '0;
      ft_lvl <= 1'b1;
    end else if (run) begin
      if (ft_cnt == FT_W'(FT_HALF - 1)) begin
        ft_cnt <= '0;
        ft_lvl <= ~ft_lvl;
      end else begin
        ft_cnt <= ft_cnt + 1'b1;
      end
    end
  end

  assign pin_drive_low = cal_q[6] ? ~ft_lvl : ~cal_q[7];
endmodule

module cal_trim_divider_chk #(
  parameter int SEC_W = 1,
  parameter int MIN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_we,
  input logic [7:0]       cal_wdata,
  input logic             stop_bit,
  input logic             div_clr,
  input logic             pwr_down,
  input logic             sec_tick,
  input logic [SEC_W-1:0] sec_pos,
  input logic [MIN_W-1:0] min_pos,
  input logic             pin_drive_low,
  input logic [7:0]       cal_q,
  input logic             ft_lvl
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  // R4
  min_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(min_pos) |-> sec_tick);
  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> (!sec_tick && $stable(ft_lvl) && $stable(min_pos)));
  // R9
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> (sec_pos == '0 && !sec_tick && $stable(min_pos)));
  // R11
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_we && !cal_wdata[6]) |=> (pin_drive_low == !$past(cal_wdata[7])));
  // R12
  pwr_ft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !cal_q[6]);
endmodule

bind cal_trim_divider cal_trim_divider_chk #(.SEC_W(SEC_W), .MIN_W(MIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cal_we(cal_we), .cal_wdata(cal_wdata),
  .stop_bit(stop_bit), .div_clr(div_clr), .pwr_down(pwr_down),
  .sec_tick(sec_tick), .sec_pos(sec_pos), .min_pos(min_pos),
  .pin_drive_low(pin_drive_low), .cal_q(cal_q), .ft_lvl(ft_lvl)
);

// File: tb/cal_trim_divider_tb_top.sv
`timescale 1ns/1ps
module cal_trim_divider_tb_top;
  localparam int OPS = 512, SPM = 2, SHORT = 256, LONG = 128, FTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, full_rate = 1'b1, ph = 1'b0;
  logic cal_we = 1'b0, stop_bit = 1'b0, div_clr = 1'b0, pwr_down = 1'b0;
  logic [7:0] cal_wdata = 8'h00;
  logic osc_en, sec_tick, pin_drive_low;
  logic [0:0] sec_pos;
  logic [5:0] min_pos;
  int n_chk = 0, n_bad = 0;
  int m_sec = 0, m_min = 0, m_mag = 0, m_sign = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) ph <= ~ph;
  assign osc_en = full_rate | ph;

  cal_trim_divider #(.OSC_PER_SEC(OPS), .SEC_PER_MIN(SPM), .MIN_PER_CYC(64),
                     .SHORTEN(SHORT), .LENGTHEN(LONG), .FT_HALF(FTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_we(cal_we), .cal_wdata(cal_wdata),
    .stop_bit(stop_bit), .div_clr(div_clr), .pwr_down(pwr_down), .sec_tick(sec_tick),
    .sec_pos(sec_pos), .min_pos(min_pos), .pin_drive_low(pin_drive_low));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int start, output int gap);
    gap = start;
    do begin
      @(negedge clk);
      cal_we = 1'b0; div_clr = 1'b0; pwr_down = 1'b0;
      gap++;
    end while (!sec_tick && gap < 5000);
  endtask

  task automatic wr(input logic [7:0] v);
    cal_we = 1'b1; cal_wdata = v;
    @(negedge clk);
    cal_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; full_rate = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sec = 0; m_min = 0; m_mag = 0; m_sign = 0;
  endtask

  function automatic int exp_len();
    if (m_sec == 0 && m_min < 2 * m_mag) return m_sign ? OPS - SHORT : OPS + LONG;
    return OPS;
  endfunction

  task automatic step_model();
    m_sec++;
    if (m_sec == SPM) begin m_sec = 0; m_min = (m_min + 1) % 64; end
  endtask

  task automatic tick_check(input int start, input int exp_gap, input string req);
    int g;
    wait_tick(start, g);
    chk(g == exp_gap, req, g, exp_gap);
    step_model();
    chk(int'(min_pos) == m_min && int'(sec_pos) == m_sec, "R4", int'(min_pos), m_min);
  endtask

  task automatic ft_intervals(input string req);
    logic p;
    int c;
    c = 0; p = pin_drive_low;
    while (pin_drive_low == p && c < 100) begin @(negedge clk); c++; end
    for (int k = 0; k < 4; k++) begin
      p = pin_drive_low; c = 0;
      while (pin_drive_low == p && c < 100) begin @(negedge clk); c++; end
      chk(c == FTH, req, c, FTH);
    end
  endtask

  initial begin
    #(195000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    bit steady;
    logic p;
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(sec_tick == 0 && sec_pos == 0 && min_pos == 0, "R1", int'(min_pos), 0);
    chk(pin_drive_low == 1'b0, "R1", int'(pin_drive_low), 0);
    // R11 / R2 static level
    wr(8'h00); chk(pin_drive_low == 1'b1, "R11", int'(pin_drive_low), 1);
    wr(8'h80); chk(pin_drive_low == 1'b0, "R11", int'(pin_drive_low), 0);
    // R10 test wave, then under maximum trim
    wr(8'h40); ft_intervals("R10");
    wr(8'h7F); ft_intervals("R10");
    // R8 test level frozen while stopped
    stop_bit = 1'b1; p = pin_drive_low; steady = 1;
    repeat (40) begin @(negedge clk); if (pin_drive_low != p) steady = 0; end
    stop_bit = 1'b0;
    chk(steady, "R8", int'(steady), 1);
    // R12 power-down forces static level, also against a same-cycle write
    wr(8'hC0); pwr_down = 1'b1; @(negedge clk); pwr_down = 1'b0; steady = 1;
    repeat (30) begin @(negedge clk); if (pin_drive_low != 1'b0) steady = 0; end
    chk(steady, "R12", int'(steady), 1);
    cal_we = 1'b1; cal_wdata = 8'h40; pwr_down = 1'b1;
    @(negedge clk); cal_we = 1'b0; pwr_down = 1'b0; steady = 1;
    repeat (30) begin @(negedge clk); if (pin_drive_low != 1'b1) steady = 0; end
    chk(steady, "R12", int'(steady), 1);

    // R3 enable spacing, R8 stop, R9 divider clear
    do_reset();
    full_rate = 1'b0;
    wait_tick(0, g); step_model();
    tick_check(0, 2 * OPS, "R3");
    full_rate = 1'b1;
    tick_check(0, OPS, "R3");
    stop_bit = 1'b1;
    repeat (50) @(negedge clk);
    stop_bit = 1'b0;
    tick_check(50, OPS + 50, "R8");
    repeat (100) @(negedge clk);
    div_clr = 1'b1; @(negedge clk); div_clr = 1'b0;
    chk(sec_pos == 0 && int'(min_pos) == m_min, "R9", int'(sec_pos), 0);
    m_sec = 0;
    tick_check(0, exp_len(), "R9");
    tick_check(0, exp_len(), "R7");

    // R5 / R7 full cycle of maximum positive trim
    do_reset();
    cal_we = 1'b1; cal_wdata = 8'hBF; m_mag = 31; m_sign = 1;
    for (int s = 0; s < 128; s++)
      tick_check(0, exp_len(), (m_sec == 0 && m_min < 62) ? "R5" : "R7");
    // R6 / R7 full cycle of unit negative trim, written on the first cycle of a second
    cal_we = 1'b1; cal_wdata = 8'h81; m_mag = 1; m_sign = 0;
    for (int s = 0; s < 128; s++)
      tick_check(0, exp_len(), (m_sec == 0 && m_min < 2) ? "R6" : "R7");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule